// File: doc/BRIEF.md
# Level-by-Level Test Mode Sequencer

This block drives the mode bits of a tree of configurable two-input gates during built-in self-test. Each gate in the tree computes either its working (system) function or an XOR, and all gates at one depth of the tree share one mode bit. In ordinary test every level runs as XOR, so the pseudorandom patterns reach every gate evenly and errors reach the tree output. That setting never exercises the mode inputs themselves. The sequencer therefore places a single level at a time in its system function and leaves every other level in XOR. It starts at the level next to the tree inputs and moves one level toward the output after each dwell.

The dwell per level is a parameter. It is sized from the wanted probability that a two-input gate sees all four input pairs, T >= ln(1 - P^(1/4)) / ln(0.75), which gives 21 clocks for P = 0.99. A full walk over a tree with n inputs lasts the dwell times ceil(log2 n) clocks, which is 105 clocks for n = 20. An internal dwell counter advances the walk by itself. An external shift strobe advances it at once and restarts the dwell. A system-mode request puts every level in its system function, aborts any walk, and leaves the sequencer idle when it is released. The pattern source and the signature compactor are outside this block.

Top module: `lvl_mode_seq`

## Requirements
- R1: After reset every mode bit is 0 (all levels in XOR test mode) and done_o is 0.
- R2: In the idle or finished state with sys_mode_i low, a test_start_i pulse makes level_sys_o equal 1 (bit 0, the level next to the tree inputs) from the next clock and clears done_o.
- R3: Unless every level is in system mode, at most one bit of level_sys_o is 1.
- R4: With no shift strobe, each level stays in system mode for exactly DWELL consecutive clocks. The single set bit then moves from bit k to bit k+1.
- R5: A shift_i pulse during a walk moves the set bit one position up at the next clock, and the new level again stays DWELL clocks.
- R6: When the top level (bit LEVELS-1) ends its dwell or receives a shift, all mode bits return to 0 and done_o rises at the next clock. An unshifted walk shows a set bit for DWELL*LEVELS clocks.
- R7: done_o stays 1 until a new test_start_i or a sys_mode_i request. shift_i has no effect on it.
- R8: While sys_mode_i is 1, every mode bit is 1 from the next clock and done_o is 0. This holds whatever test_start_i and shift_i do. After release the sequencer is idle with all bits 0, and a walk that was aborted does not resume.
- R9: test_start_i during a walk is ignored; the active level and its dwell continue unchanged.
- R10: shift_i while idle is ignored; all mode bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_start_i | input | 1 | Request to begin a level walk |
| shift_i | input | 1 | Strobe that advances the active level at once |
| sys_mode_i | input | 1 | Places all levels in their system function; overrides everything |
| level_sys_o | output | LEVELS | One bit per tree level, bit 0 nearest the inputs; 1 = system function, 0 = XOR test mode |
| done_o | output | 1 | Set after the last level finishes |

## Verification
An unshifted walk checks, cycle by cycle, that each level holds for the full dwell and that done follows the last level one clock later. A walk driven by strobes, including two strobes in a row and a strobe on the top level, separates an immediate advance and restart of the dwell from the advance the counter makes by itself. The bench raises system-mode requests during a walk, while done is set, and together with start and shift. These show that the override wins and that the walk does not come back after release. Start pulses during a walk and shift pulses while idle or done must leave the outputs unchanged.

// File: rtl/lms_pkg.sv
package lms_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // all levels in XOR test mode, waiting
        ST_SYS  = 2'd1,   // every level forced to system function
        ST_WALK = 2'd2,   // one level in system function, walking upward
        ST_FIN  = 2'd3    // walk complete, done flag held
    } seq_state_e;

    function automatic int unsigned levels_for(input int unsigned n_inputs);
        return (n_inputs > 2) ? $clog2(n_inputs) : 1;
    endfunction

endpackage

// File: rtl/lms_dwell_timer.sv
module lms_dwell_timer #(
    parameter int unsigned DWELL = 21
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,      // walk in progress
    input  logic restart_i,  // external strobe restarts the dwell
    output logic expire_o    // last clock of the current dwell
);
    localparam int unsigned CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expire_o = run_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
        if (!run_i || restart_i || expire_o) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/lms_mode_drive.sv
module lms_mode_drive #(
    parameter int unsigned LEVELS = 5
) (
    input  logic [LEVELS-1:0] walk_i,     // one-hot active level
    input  logic              all_sys_i,  // global system-mode override
    output logic [LEVELS-1:0] level_sys_o
);
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign level_sys_o[g] = all_sys_i | walk_i[g];
    end
endmodule

// File: rtl/lvl_mode_seq.sv
module lvl_mode_seq
    import lms_pkg::*;
#(
    parameter int unsigned N_INPUTS = 20,
    parameter int unsigned DWELL    = 21,
    localparam int unsigned LEVELS  = levels_for(N_INPUTS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              test_start_i,
    input  logic              shift_i,
    input  logic              sys_mode_i,
    output logic [LEVELS-1:0] level_sys_o,
    output logic              done_o
);
    localparam logic [LEVELS-1:0] FIRST_LVL = LEVELS'(1);

    typedef struct packed {
        seq_state_e        state;
        logic [LEVELS-1:0] walk;   // one-hot active level
        logic              done;
    } seq_reg_t;

    seq_reg_t r_d, r_q;
    logic     dwell_end;
    logic     step;
    logic     walking;

    assign walking = (r_q.state == ST_WALK);
    assign step    = walking && (shift_i || dwell_end);

    lms_dwell_timer #(
        .DWELL (DWELL)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (walking),
        .restart_i (shift_i),
        .expire_o  (dwell_end)
    );

    always_comb begin
        r_d = r_q;
        if (sys_mode_i) begin
            r_d.state = ST_SYS;
            r_d.walk  = '0;
            r_d.done  = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE, ST_FIN: begin
                    if (test_start_i) begin
                        r_d.state = ST_WALK;
                        r_d.walk  = FIRST_LVL;
                        r_d.done  = 1'b0;
                    end
                end
                ST_SYS: begin
                    r_d.state = ST_IDLE;
                    r_d.walk  = '0;
                    r_d.done  = 1'b0;
                end
                ST_WALK: begin
                    if (step) begin
                        if (r_q.walk[LEVELS-1]) begin
                            r_d.state = ST_FIN;
                            r_d.walk  = '0;
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.walk = r_q.walk << 1;
                        end
                    end
                end
                default: begin
                    r_d.state = ST_IDLE;
                    r_d.walk  = '0;
                    r_d.done  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= ST_IDLE;
            r_q.walk  <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    lms_mode_drive #(
        .LEVELS (LEVELS)
    ) u_drive (
        .walk_i      (r_q.walk),
        .all_sys_i   (r_q.state == ST_SYS),
        .level_sys_o (level_sys_o)
    );

    assign done_o = r_q.done;
endmodule

// File: rtl/lms_seq_checker.sv
module lms_seq_checker
    import lms_pkg::*;
#(
    parameter int unsigned N_INPUTS = 20,
    parameter int unsigned DWELL    = 21,
    localparam int unsigned LEVELS  = levels_for(N_INPUTS)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              test_start_i,
    input logic              shift_i,
    input logic              sys_mode_i,
    input logic [LEVELS-1:0] level_sys_o,
    input logic              done_o
);
    logic [LEVELS-1:0] prev_lvl;
    int unsigned       hold_cnt;
    logic              single;

    assign single = ($countones(level_sys_o) == 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_lvl <= '0;
            hold_cnt <= 0;
        end else begin
            prev_lvl <= level_sys_o;
            hold_cnt <= (single && level_sys_o == prev_lvl) ? hold_cnt + 1 : 0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |-> (level_sys_o == '0 && !done_o)); // R1

    AST_START_LEVEL1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (test_start_i && !sys_mode_i && level_sys_o == '0)
        |=> (level_sys_o == LEVELS'(1) && !done_o)); // R2

    AST_ONE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($onehot0(level_sys_o) || (&level_sys_o))); // R3

    AST_DWELL_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_cnt < DWELL)); // R4

    AST_SHIFT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_i && !sys_mode_i && single && !level_sys_o[LEVELS-1])
        |=> (level_sys_o == ($past(level_sys_o) << 1))); // R5

    AST_TOP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_i && !sys_mode_i && single && level_sys_o[LEVELS-1])
        |=> (done_o && level_sys_o == '0)); // R6

    AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !sys_mode_i && !test_start_i) |=> done_o); // R7

    AST_SYS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_mode_i |=> ((&level_sys_o) && !done_o)); // R8

    AST_IDLE_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_sys_o == '0 && !done_o && !test_start_i && !sys_mode_i)
        |=> (level_sys_o == '0)); // R10
endmodule

bind lvl_mode_seq lms_seq_checker #(
    .N_INPUTS (N_INPUTS),
    .DWELL    (DWELL)
) u_seq_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .test_start_i (test_start_i),
    .shift_i      (shift_i),
    .sys_mode_i   (sys_mode_i),
    .level_sys_o  (level_sys_o),
    .done_o       (done_o)
);

// File: tb/test_lvl_mode_seq.sv
module test_lvl_mode_seq;
    localparam int unsigned N_INPUTS = 20;
    localparam int unsigned DWELL    = 21;
    localparam int unsigned LEVELS   = 5;
    localparam logic [LEVELS-1:0] ALL = {LEVELS{1'b1}};

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              test_start_i = 1'b0;
    logic              shift_i = 1'b0;
    logic              sys_mode_i = 1'b0;
    logic [LEVELS-1:0] level_sys_o;
    logic              done_o;

    always #2 clk = ~clk;  // 250 MHz

    lvl_mode_seq #(
        .N_INPUTS (N_INPUTS),
        .DWELL    (DWELL)
    ) i_lvl_mode_seq (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .test_start_i (test_start_i),
        .shift_i      (shift_i),
        .sys_mode_i   (sys_mode_i),
        .level_sys_o  (level_sys_o),
        .done_o       (done_o)
    );

    typedef struct {
        logic [LEVELS-1:0] lvl;
        logic              done;
        string             req;
    } exp_t;

    exp_t        sb[$];
    int unsigned n_cmp  = 0;
    int unsigned n_bad  = 0;
    int unsigned walk_len = 0;
    bit          finished = 1'b0;

    task automatic report(input string req, input logic [LEVELS-1:0] al, input logic ad,
                          input logic [LEVELS-1:0] el, input logic ed);
        n_cmp++;
        if (al !== el || ad !== ed) begin
            n_bad++;
            $display("FAIL %s actual lvl=%b done=%b expected lvl=%b done=%b",
                     req, al, ad, el, ed);
        end
    endtask

    // driver: apply inputs for one clock and queue the outputs expected after it
    task automatic step(input logic st, input logic sh, input logic sy,
                        input logic [LEVELS-1:0] lvl, input logic dn, input string req);
        exp_t e;
        @(negedge clk);
        test_start_i = st;
        shift_i      = sh;
        sys_mode_i   = sy;
        e.lvl  = lvl;
        e.done = dn;
        e.req  = req;
        sb.push_back(e);
    endtask

    // monitor: compare one expected item after every edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                report(e.req, level_sys_o, done_o, e.lvl, e.done);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        report("R1 in reset", level_sys_o, done_o, '0, 1'b0);
        @(negedge clk);
        rst_ni = 1'b1;
        step(0, 0, 0, '0, 0, "R1 after reset");
        step(0, 0, 0, '0, 0, "R1 after reset");

        // R10: shift while idle
        step(0, 1, 0, '0, 0, "R10 shift idle");
        step(0, 0, 0, '0, 0, "R10 shift idle");

        // R2 + R4 + R9 + R6: unshifted full walk
        step(1, 0, 0, LEVELS'(1), 0, "R2 start");
        walk_len = 1;
        for (int k = 1; k < DWELL; k++) begin
            step(0, 0, 0, LEVELS'(1), 0, "R4 dwell level0");
            walk_len++;
        end
        for (int lv = 1; lv < LEVELS; lv++) begin
            for (int k = 0; k < DWELL; k++) begin
                if (lv == 2 && k == 5)
                    step(1, 0, 0, LEVELS'(1) << lv, 0, "R9 start ignored");
                else
                    step(0, 0, 0, LEVELS'(1) << lv, 0, "R4 dwell upper level");
                walk_len++;
            end
        end
        step(0, 0, 0, '0, 1, "R6 done after last dwell");
        n_cmp++;
        if (walk_len != DWELL * LEVELS) begin
            n_bad++;
            $display("FAIL R6 walk length actual=%0d expected=%0d", walk_len, DWELL * LEVELS);
        end

        // R7: done held, shift has no effect
        step(0, 1, 0, '0, 1, "R7 done hold shift");
        step(0, 0, 0, '0, 1, "R7 done hold");
        step(0, 0, 0, '0, 1, "R7 done hold");

        // R5: strobes, then R6 via strobe on top level
        step(1, 0, 0, LEVELS'(1), 0, "R2 restart from done");
        step(0, 0, 0, LEVELS'(1), 0, "R5 pre-shift");
        step(0, 0, 0, LEVELS'(1), 0, "R5 pre-shift");
        step(0, 1, 0, LEVELS'(2), 0, "R5 shift");
        step(0, 1, 0, LEVELS'(4), 0, "R5 back-to-back shift");
        for (int k = 1; k < DWELL; k++)
            step(0, 0, 0, LEVELS'(4), 0, "R5 dwell restarted");
        step(0, 0, 0, LEVELS'(8), 0, "R4 advance after restarted dwell");
        step(0, 1, 0, LEVELS'(16), 0, "R5 shift to top");
        step(0, 1, 0, '0, 1, "R6 shift on top level");
        step(0, 0, 0, '0, 1, "R7 done hold");

        // R8: override during done
        step(0, 0, 1, ALL, 0, "R8 sys from done");
        step(0, 0, 0, '0, 0, "R8 release to idle");
        step(0, 0, 0, '0, 0, "R8 idle after release");

        // R8: override during walk, with start and shift active
        step(1, 0, 0, LEVELS'(1), 0, "R2 start");
        step(0, 1, 0, LEVELS'(2), 0, "R5 shift");
        step(0, 1, 1, ALL, 0, "R8 sys beats shift");
        step(1, 1, 1, ALL, 0, "R8 sys beats start");
        step(0, 0, 1, ALL, 0, "R8 sys held");
        step(0, 0, 0, '0, 0, "R8 release to idle");
        for (int k = 0; k < DWELL + 2; k++)
            step(0, 0, 0, '0, 0, "R8 walk not resumed");

        // R2 after release
        step(1, 0, 0, LEVELS'(1), 0, "R2 start after sys");
        step(0, 0, 0, LEVELS'(1), 0, "R3 single level");

        @(negedge clk);
        test_start_i = 1'b0;
        shift_i      = 1'b0;
        sys_mode_i   = 1'b0;
        wait (sb.size() == 0);
        @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule